// File: doc/BRIEF.md
# Fully Associative Instruction Cache with FIFO Replacement

This block is a small read-only cache in which any memory block may occupy any entry. No address bits select a location. The full tag of an incoming request is compared against the stored tag of every entry at once, one comparator per entry. The comparators produce a one-hot hit vector, and that vector selects the block to read. A word field in the address then picks one word out of that block.

On a miss the cache raises a stall toward the requester and issues a block-aligned fetch on a single-beat block memory port. The returned block goes into the entry named by a circular victim pointer. The pointer steps once per completed refill and is never moved by hits, so replacement is oldest-installed first. A flush input empties the cache, rewinds the pointer and abandons any fetch in progress. The requester holds its request steady while stall is high. In the cycle after the refill lands, the held request hits and the word is returned.

Top module: `fa_icache`

## Requirements
- R1: The 32-bit address splits into a tag (bits 31:5), a word select (bits 4:2) and an ignored byte field (bits 1:0). Word k of a returned block sits at bits 32k+31:32k of the memory data bus.
- R2: If a request matches a valid entry, rvalid_o is 1 and stall_o is 0 in the same cycle, and rdata_o carries the selected word of that entry.
- R3: If a request matches no valid entry, stall_o is 1 in that cycle. From the next cycle, mem_req_o is 1 with mem_addr_o equal to the request address with bits 4:0 cleared, and it stays so until mem_valid_i.
- R4: stall_o stays 1 through the cycle in which mem_valid_i is accepted. In the following cycle the held request hits and returns the word from the new block.
- R5: At most one entry matches any tag, because a refill only happens after a miss.
- R6: After reset or flush, refills fill entries 0 to N-1 in order. After that, each miss replaces the entry installed longest ago, and the pointer wraps modulo N.
- R7: Hits do not change the victim choice. A block that is hit repeatedly is still the next one evicted if it is the oldest.
- R8: flush_i invalidates every entry and rewinds the victim pointer. Every later request misses until it is refilled. A flush during a refill drops mem_req_o in the next cycle and installs nothing.
- R9: In reset, stall_o, rvalid_o and mem_req_o are 0 and all entries are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all entries, abort refill |
| req_i | input | 1 | Read request, held while stall_o |
| addr_i | input | 32 | Byte address of request |
| stall_o | output | 1 | Request cannot complete this cycle |
| rvalid_o | output | 1 | rdata_o is valid for the request |
| rdata_o | output | 32 | Selected instruction word |
| mem_req_o | output | 1 | Block fetch pending |
| mem_addr_o | output | 32 | Block-aligned fetch address |
| mem_valid_i | input | 1 | Block data present on mem_data_i |
| mem_data_i | input | 256 | Whole block, word 0 in lowest bits |

## Verification
Some rules can be checked on every cycle, and the assertions cover those. The hit vector must never have more than one bit set. A hit must never coincide with stall or a pending fetch. A miss must open a fetch for the right block address. Hits must leave the victim pointer unchanged, and each refill must step it by one with wrap. A flush must suppress hits in the following cycle. Other behaviour depends on what a sequence of accesses leaves behind, and only the bench's scenarios can show it. This includes the FIFO eviction order once the cache is full, blocks surviving while the pointer moves past them, word selection within a refilled block, and a refill aborted by flush leaving no entry installed.

// File: rtl/fa_icache_pkg.sv
package fa_icache_pkg;
  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_REFILL = 1'b1
  } fill_state_e;
endpackage

// File: rtl/fa_tag_match.sv
module fa_tag_match #(
  parameter int N_ENTRIES = 8,
  parameter int TAG_W     = 27,
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic [TAG_W-1:0]     tags_i [N_ENTRIES],
  input  logic [N_ENTRIES-1:0] valid_i,
  input  logic [TAG_W-1:0]     tag_i,
  output logic [N_ENTRIES-1:0] hit_vec_o,
  output logic                 hit_o,
  output logic [IDX_W-1:0]     hit_idx_o
);
  // one comparator per entry
  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    assign hit_vec_o[g] = valid_i[g] && (tags_i[g] == tag_i);
  end

  assign hit_o = |hit_vec_o;

  always_comb begin
    hit_idx_o = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (hit_vec_o[i]) hit_idx_o = hit_idx_o | IDX_W'(i);
    end
  end
endmodule

// File: rtl/fa_rr_ptr.sv
module fa_rr_ptr #(
  parameter int N_ENTRIES = 8,
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] ptr_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENTRIES - 1);

  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_q <= '0;
    else if (clr_i)   ptr_q <= '0;
    else if (adv_i)   ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/fa_block_store.sv
module fa_block_store #(
  parameter int N_ENTRIES = 8,
  parameter int TAG_W     = 27,
  parameter int BLOCK_W   = 256,
  parameter int WORD_W    = 32,
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
  localparam int N_WORDS  = BLOCK_W / WORD_W,
  localparam int WSEL_W   = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 we_i,
  input  logic [IDX_W-1:0]     wr_idx_i,
  input  logic [TAG_W-1:0]     wr_tag_i,
  input  logic [BLOCK_W-1:0]   wr_data_i,
  input  logic [N_ENTRIES-1:0] rd_sel_i,
  input  logic [WSEL_W-1:0]    word_sel_i,
  output logic [TAG_W-1:0]     tags_o [N_ENTRIES],
  output logic [N_ENTRIES-1:0] valid_o,
  output logic [WORD_W-1:0]    rdata_o
);
  logic [N_ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]     tag_q  [N_ENTRIES];
  logic [BLOCK_W-1:0]   data_q [N_ENTRIES];
  logic [BLOCK_W-1:0]   blk_sel;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        tag_q[g]   <= '0;
        data_q[g]  <= '0;
      end else if (clr_i) begin
        valid_q[g] <= 1'b0;
      end else if (we_i && (wr_idx_i == IDX_W'(g))) begin
        valid_q[g] <= 1'b1;
        tag_q[g]   <= wr_tag_i;
        data_q[g]  <= wr_data_i;
      end
    end
    assign tags_o[g] = tag_q[g];
  end

  assign valid_o = valid_q;

  // AND-OR mux driven by the one-hot hit vector
  always_comb begin
    blk_sel = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      blk_sel = blk_sel | (data_q[i] & {BLOCK_W{rd_sel_i[i]}});
    end
  end

  assign rdata_o = blk_sel[word_sel_i*WORD_W +: WORD_W];
endmodule

// File: rtl/fa_icache.sv
module fa_icache
  import fa_icache_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int OFFSET_W  = 5,
  parameter int WORD_W    = 32,
  parameter int N_ENTRIES = 8,
  localparam int TAG_W    = ADDR_W - OFFSET_W,
  localparam int BLOCK_W  = 8 * (1 << OFFSET_W),
  localparam int N_WORDS  = BLOCK_W / WORD_W,
  localparam int WSEL_W   = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
  localparam int BYTE_W   = $clog2(WORD_W / 8),
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_i,
  input  logic               req_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic               stall_o,
  output logic               rvalid_o,
  output logic [WORD_W-1:0]  rdata_o,
  output logic               mem_req_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  input  logic               mem_valid_i,
  input  logic [BLOCK_W-1:0] mem_data_i
);
  fill_state_e          state_q, state_d;
  logic [TAG_W-1:0]     miss_tag_q;
  logic [TAG_W-1:0]     req_tag;
  logic [WSEL_W-1:0]    word_sel;
  logic [N_ENTRIES-1:0] hit_vec, valid_vec;
  logic [TAG_W-1:0]     tags [N_ENTRIES];
  logic                 hit;
  logic [IDX_W-1:0]     hit_idx, victim;
  logic                 lookup_hit, lookup_miss, refill_done;
  logic [BYTE_W-1:0]    unused_byte;

  assign req_tag     = addr_i[ADDR_W-1:OFFSET_W];
  assign word_sel    = addr_i[OFFSET_W-1:BYTE_W];
  assign unused_byte = addr_i[BYTE_W-1:0];

  fa_tag_match #(.N_ENTRIES(N_ENTRIES), .TAG_W(TAG_W)) u_match (
    .tags_i    (tags),
    .valid_i   (valid_vec),
    .tag_i     (req_tag),
    .hit_vec_o (hit_vec),
    .hit_o     (hit),
    .hit_idx_o (hit_idx)
  );

  assign lookup_hit  = (state_q == ST_IDLE) && req_i && hit;
  assign lookup_miss = (state_q == ST_IDLE) && req_i && !hit;
  assign refill_done = (state_q == ST_REFILL) && mem_valid_i && !flush_i;

  fa_rr_ptr #(.N_ENTRIES(N_ENTRIES)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (flush_i),
    .adv_i  (refill_done),
    .ptr_o  (victim)
  );

  fa_block_store #(
    .N_ENTRIES(N_ENTRIES), .TAG_W(TAG_W), .BLOCK_W(BLOCK_W), .WORD_W(WORD_W)
  ) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (flush_i),
    .we_i       (refill_done),
    .wr_idx_i   (victim),
    .wr_tag_i   (miss_tag_q),
    .wr_data_i  (mem_data_i),
    .rd_sel_i   (hit_vec),
    .word_sel_i (word_sel),
    .tags_o     (tags),
    .valid_o    (valid_vec),
    .rdata_o    (rdata_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (lookup_miss && !flush_i) state_d = ST_REFILL;
      ST_REFILL: if (flush_i || mem_valid_i) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      miss_tag_q <= '0;
    end else begin
      state_q <= state_d;
      if (lookup_miss) miss_tag_q <= req_tag;
    end
  end

  assign stall_o    = lookup_miss || (state_q == ST_REFILL);
  assign rvalid_o   = lookup_hit;
  assign mem_req_o  = (state_q == ST_REFILL);
  assign mem_addr_o = {miss_tag_q, {OFFSET_W{1'b0}}};

  // R5
  hit_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));

  // R2
  hit_no_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> (!stall_o && !mem_req_o));

  // R3
  miss_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !hit && !mem_req_o && !flush_i) |=>
      (mem_req_o && mem_addr_o[ADDR_W-1:OFFSET_W] == $past(addr_i[ADDR_W-1:OFFSET_W])));

  // R7
  hit_ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && !flush_i) |=> $stable(victim));

  // R6
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_valid_i && !flush_i) |=>
      (victim == (($past(victim) == IDX_W'(N_ENTRIES - 1)) ? '0 : $past(victim) + 1'b1)));

  // R8
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !rvalid_o);
endmodule

// File: tb/fa_icache_tb_top.sv
`timescale 1ns/1ps
module fa_icache_tb_top;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         flush_i = 1'b0;
  logic         req_i = 1'b0;
  logic [31:0]  addr_i = '0;
  logic         stall_o, rvalid_o, mem_req_o;
  logic [31:0]  rdata_o, mem_addr_o;
  logic         mem_valid_i = 1'b0;
  logic [255:0] mem_data_i = '0;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2 clk_i = ~clk_i;

  fa_icache dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i), .req_i(req_i),
    .addr_i(addr_i), .stall_o(stall_o), .rvalid_o(rvalid_o), .rdata_o(rdata_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_valid_i(mem_valid_i), .mem_data_i(mem_data_i)
  );

  localparam int NV = 8;
  localparam logic [31:0] VEC_ADDR [NV] = '{
    32'h0000_1000, 32'h0000_1004, 32'h0000_101C, 32'h8000_1000,
    32'h8000_1008, 32'h0000_1010, 32'h0000_1020, 32'h8000_1014};
  localparam bit VEC_HIT [NV] = '{0, 1, 1, 0, 1, 1, 0, 1};

  function automatic logic [31:0] mem_word(input logic [31:0] a, input int k);
    logic [31:0] b;
    b = {a[31:5], 5'b0};
    return b ^ (32'h0101_0101 * (k + 1)) ^ 32'h5A00_00A5;
  endfunction

  function automatic logic [255:0] mem_block(input logic [31:0] a);
    logic [255:0] r;
    for (int k = 0; k < 8; k++) r[k*32 +: 32] = mem_word(a, k);
    return r;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] a, input bit exp_hit, input string rq);
    bit missed;
    @(negedge clk_i);
    req_i = 1'b1; addr_i = a;
    #1;
    missed = stall_o;
    chk(missed != exp_hit, rq, {31'b0, !missed}, {31'b0, exp_hit});
    if (missed) begin
      chk(!rvalid_o, "R3", {31'b0, rvalid_o}, 32'h0);
      @(negedge clk_i);
      chk(mem_req_o, "R3", {31'b0, mem_req_o}, 32'h1);
      chk(mem_addr_o == {a[31:5], 5'b0}, "R3", mem_addr_o, {a[31:5], 5'b0});
      repeat (2) @(negedge clk_i);
      chk(stall_o && mem_req_o, "R4", {31'b0, stall_o}, 32'h1);
      mem_valid_i = 1'b1; mem_data_i = mem_block(a);
      #1;
      chk(stall_o, "R4", {31'b0, stall_o}, 32'h1);
      @(negedge clk_i);
      mem_valid_i = 1'b0;
      #1;
    end
    chk(rvalid_o && !stall_o, "R2", {30'b0, rvalid_o, stall_o}, 32'h2);
    chk(rdata_o == mem_word(a, int'(a[4:2])), "R1", rdata_o, mem_word(a, int'(a[4:2])));
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk_i);
    flush_i = 1'b1;
    @(negedge clk_i);
    flush_i = 1'b0;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R9 reset state
    repeat (3) @(negedge clk_i);
    chk(!stall_o && !rvalid_o && !mem_req_o, "R9",
        {29'b0, stall_o, rvalid_o, mem_req_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!stall_o && !mem_req_o, "R9", {30'b0, stall_o, mem_req_o}, 32'h0);

    // table walk: R1 R2 R3 R4
    for (int i = 0; i < NV; i++) access(VEC_ADDR[i], VEC_HIT[i], "R2/R3 table");

    // fill remaining entries 3..7, R6
    for (int i = 3; i < 8; i++) access((32'(i) << 28) | 32'h40, 1'b0, "R6 fill");
    access(32'h0000_1000, 1'b1, "R6 all resident");
    access(32'h7000_0044, 1'b1, "R6 all resident");

    // R7: hits on oldest block do not protect it
    access(32'h0000_1000, 1'b1, "R7 hit oldest");
    access(32'h0000_1008, 1'b1, "R7 hit oldest");
    access(32'h0000_9000, 1'b0, "R7 new block");
    access(32'h0000_1020, 1'b1, "R6 survivor");
    access(32'h8000_1000, 1'b1, "R6 survivor");
    access(32'h0000_1000, 1'b0, "R7 oldest evicted");
    access(32'h8000_1000, 1'b0, "R6 next oldest evicted");
    access(32'h0000_1020, 1'b0, "R6 third evicted");
    access(32'h0000_9000, 1'b1, "R6 recent kept");

    // R8 flush
    do_flush();
    #1;
    chk(!rvalid_o && !stall_o, "R8", {30'b0, rvalid_o, stall_o}, 32'h0);
    access(32'h0000_9000, 1'b0, "R8 miss after flush");

    // R8 flush aborts refill
    @(negedge clk_i);
    req_i = 1'b1; addr_i = 32'h0000_5000;
    #1;
    chk(stall_o, "R3", {31'b0, stall_o}, 32'h1);
    @(negedge clk_i);
    chk(mem_req_o, "R3", {31'b0, mem_req_o}, 32'h1);
    flush_i = 1'b1; req_i = 1'b0;
    @(negedge clk_i);
    flush_i = 1'b0;
    #1;
    chk(!mem_req_o && !stall_o, "R8 abort", {30'b0, mem_req_o, stall_o}, 32'h0);
    access(32'h0000_5000, 1'b0, "R8 nothing installed");
    access(32'h0000_9000, 1'b0, "R8 flushed");

    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule